// File: doc/BRIEF.md
# Up/Down PWM Time-Base Counter with Coherent Byte Read

This block is the time base of a pulse-width modulator. A 12-bit counter either climbs repeatedly from 1 to a programmable modulus (edge-aligned operation) or climbs to the modulus and then descends back to 1 (center-aligned operation). Each completed period yields a one-cycle reload pulse. Downstream compare logic can use this pulse to take on new duty values.

Software reads the count over an 8-bit path as two bytes. A read strobe on the upper byte returns the top four count bits. In the same cycle it freezes the lower byte of the count. The lower-byte port keeps returning that frozen value until the lower byte is itself read, so the two reads always form one consistent 12-bit sample. When the enable input is low, the counter sits at zero and does not move.

Top module: `pwm_updown_timebase`

## Requirements
- R1: During reset and directly after it, `cnt_o`, `reload` and both read-data ports are all zero.
- R2: While `enable` is low, `cnt_o` is 0 from the next clock edge and stays there. Leaving it low also resets the direction to counting up.
- R3: With `enable` high and `center_mode` low, the count advances by one per clock, starting at 1. On the edge after it reaches the modulus (or any value above it), it returns to 1. A period is M cycles long.
- R4: With `enable` high and `center_mode` high, the count rises 1, 2, ..., M, then falls M-1, ..., 1, then rises again from 2. A period is 2*(M-1) cycles long.
- R5: A `modulus` value of 0 or 1 behaves exactly like a modulus of 2.
- R6: `reload` is high for exactly one cycle per completed period. In edge-aligned mode it is high in the cycle in which the count has just returned to 1. In center-aligned mode it is high in the cycle in which the count has just turned from 1 to 2. It is never high for the first pass after enabling.
- R7: `rd_hi_data` carries count bits 11..8 in bits 3..0, with bits 7..4 zero. It reflects the live count in the same cycle.
- R8: A cycle with `rd_hi` high captures count bits 7..0. From the next cycle on, `rd_lo_data` returns that captured byte, and it does so whether or not the counter is enabled. The cycle with `rd_lo` high still returns the captured byte. After that cycle, `rd_lo_data` follows the live count bits 7..0 again.
- R9: When `rd_hi` and `rd_lo` are high in the same cycle, the capture wins and the low byte stays frozen afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the counter; low clears and holds it at 0 |
| center_mode | input | 1 | 1 = up/down (center-aligned), 0 = up-only (edge-aligned) |
| modulus | input | 12 | Period limit M; values below 2 are treated as 2 |
| rd_hi | input | 1 | Read strobe for the upper byte; captures the lower byte |
| rd_lo | input | 1 | Read strobe for the lower byte; releases the capture |
| rd_hi_data | output | 8 | Upper byte: zero-extended count bits 11..8 |
| rd_lo_data | output | 8 | Lower byte: captured or live count bits 7..0 |
| cnt_o | output | 12 | Live count for compare logic |
| reload | output | 1 | One-cycle pulse per completed period |

## Verification
The read-data ports are combinational, so they are due in the same cycle that the strobe is driven. The count, the reload pulse and the effect of a strobe on later lower-byte reads are all registered, so they are due one rising edge later. The bench drives every input on the falling edge and samples the read data 2 ns afterwards, still before the next rising edge. It then samples the count and reload 1 ns after that rising edge and compares them with a closed-form position within the period, derived from the number of cycles enabled. Small moduli, including 0 and 1, are swept in both modes. A modulus of 300 exercises the upper byte and the capture/release sequence.

// File: rtl/ctr_pkg.sv
package ctr_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
endpackage

// File: rtl/ctr_core.sv
module ctr_core
  import ctr_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             center_mode,
  input  logic [CNT_W-1:0] modulus,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] mod_eff,
  output logic             dir_down,
  output logic             wrap_evt,
  output logic             reload
);
  localparam logic [CNT_W-1:0] MIN_MOD = CNT_W'(2);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  function automatic logic [CNT_W-1:0] clamp_mod(input logic [CNT_W-1:0] m);
    return (m < MIN_MOD) ? MIN_MOD : m;
  endfunction

  dir_e             dir_q, dir_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_top, at_bottom;

  assign mod_eff   = clamp_mod(modulus);
  assign at_top    = (cnt_q >= mod_eff);
  assign at_bottom = (cnt_q <= ONE);

  always_comb begin
    cnt_d    = cnt_q;
    dir_d    = dir_q;
    wrap_evt = 1'b0;
    if (!enable) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (!center_mode) begin
      if (at_top) begin
        cnt_d    = ONE;
        wrap_evt = 1'b1;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else if (dir_q == DIR_UP) begin
      if (at_top) begin
        cnt_d = cnt_q - ONE;
        dir_d = DIR_DOWN;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (at_bottom) begin
        cnt_d    = cnt_q + ONE;
        dir_d    = DIR_UP;
        wrap_evt = 1'b1;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= DIR_UP;
      reload <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      reload <= wrap_evt;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = (dir_q == DIR_DOWN);
endmodule

// File: rtl/ctr_rd_latch.sv
module ctr_rd_latch #(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] hi_data,
  output logic [BYTE_W-1:0] lo_data,
  output logic              lo_frozen
);
  localparam int HI_W  = CNT_W - BYTE_W;
  localparam int PAD_W = BYTE_W - HI_W;

  logic [BYTE_W-1:0] lo_live;
  logic [BYTE_W-1:0] lo_cap_q;
  logic              held_q;

  assign lo_live = cnt[BYTE_W-1:0];
  assign hi_data = {{PAD_W{1'b0}}, cnt[CNT_W-1:BYTE_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cap_q <= '0;
      held_q   <= 1'b0;
    end else if (rd_hi) begin
      lo_cap_q <= lo_live;
      held_q   <= 1'b1;
    end else if (rd_lo) begin
      held_q   <= 1'b0;
    end
  end

  assign lo_data   = held_q ? lo_cap_q : lo_live;
  assign lo_frozen = held_q;
endmodule

// File: rtl/pwm_updown_timebase.sv
module pwm_updown_timebase #(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              center_mode,
  input  logic [CNT_W-1:0]  modulus,
  input  logic              rd_hi,
  input  logic              rd_lo,
  output logic [BYTE_W-1:0] rd_hi_data,
  output logic [BYTE_W-1:0] rd_lo_data,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              reload
);
  logic [CNT_W-1:0] mod_eff;
  logic             dir_down;
  logic             wrap_evt;
  logic             lo_frozen;

  ctr_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .center_mode (center_mode),
    .modulus     (modulus),
    .cnt         (cnt_o),
    .mod_eff     (mod_eff),
    .dir_down    (dir_down),
    .wrap_evt    (wrap_evt),
    .reload      (reload)
  );

  ctr_rd_latch #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt       (cnt_o),
    .rd_hi     (rd_hi),
    .rd_lo     (rd_lo),
    .hi_data   (rd_hi_data),
    .lo_data   (rd_lo_data),
    .lo_frozen (lo_frozen)
  );
endmodule

// File: rtl/ctr_chk.sv
module ctr_chk #(
  parameter int CNT_W  = 12,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              center_mode,
  input logic [CNT_W-1:0]  modulus,
  input logic [CNT_W-1:0]  mod_eff,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              dir_down,
  input logic              wrap_evt,
  input logic              reload,
  input logic              rd_hi,
  input logic              rd_lo,
  input logic              lo_frozen,
  input logic [BYTE_W-1:0] rd_lo_data
);
  p_disabled_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cnt_o == '0);

  p_edge_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !center_mode && cnt_o >= mod_eff |=> cnt_o == CNT_W'(1));

  p_center_turn_r4: assert property (@(posedge clk) disable iff (!rst_n)
    enable && center_mode && dir_down && cnt_o == CNT_W'(1) |=> cnt_o == CNT_W'(2));

  p_small_mod_r5: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !center_mode && modulus < CNT_W'(2) && cnt_o == CNT_W'(2) |=> cnt_o == CNT_W'(1));

  p_reload_follows_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> reload);

  p_reload_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !reload);

  p_reload_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> (cnt_o == CNT_W'(1) || cnt_o == CNT_W'(2)));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> rd_lo_data == $past(cnt_o[BYTE_W-1:0]));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo && !rd_hi |=> rd_lo_data == cnt_o[BYTE_W-1:0]);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_frozen && !rd_hi && !rd_lo |=> $stable(rd_lo_data));

  p_both_strobes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi && rd_lo |=> lo_frozen);
endmodule

bind pwm_updown_timebase ctr_chk #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .center_mode (center_mode),
  .modulus     (modulus),
  .mod_eff     (mod_eff),
  .cnt_o       (cnt_o),
  .dir_down    (dir_down),
  .wrap_evt    (wrap_evt),
  .reload      (reload),
  .rd_hi       (rd_hi),
  .rd_lo       (rd_lo),
  .lo_frozen   (lo_frozen),
  .rd_lo_data  (rd_lo_data)
);

// File: tb/pwm_updown_timebase_test.sv
`timescale 1ns/1ps
module pwm_updown_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        center_mode = 1'b0;
  logic [11:0] modulus = '0;
  logic        rd_hi = 1'b0;
  logic        rd_lo = 1'b0;
  logic [7:0]  rd_hi_data, rd_lo_data;
  logic [11:0] cnt_o;
  logic        reload;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int exp_cnt = 0;
  int exp_rel = 0;
  int m_held = 0;
  int m_lat = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_updown_timebase uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .center_mode(center_mode),
    .modulus(modulus), .rd_hi(rd_hi), .rd_lo(rd_lo),
    .rd_hi_data(rd_hi_data), .rd_lo_data(rd_lo_data),
    .cnt_o(cnt_o), .reload(reload)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Closed-form position in the period after k enabled cycles.
  function automatic int pos_count(input int kk, input bit ctr, input int me);
    int p;
    if (kk == 0) return 0;
    if (!ctr) return ((kk - 1) % me) + 1;
    p = (kk - 1) % (2 * (me - 1));
    return (p < me - 1) ? p + 1 : 2 * me - 1 - p;
  endfunction

  function automatic int pos_reload(input int kk, input bit ctr, input int me);
    if (kk == 0) return 0;
    if (!ctr) return (kk > 1 && ((kk - 1) % me) == 0) ? 1 : 0;
    return (kk > 2 && ((kk - 1) % (2 * (me - 1))) == 1) ? 1 : 0;
  endfunction

  task automatic step(input bit en, input bit ctr, input int m,
                      input bit hi, input bit lo, input string tag);
    int me;
    @(negedge clk);
    enable = en; center_mode = ctr; modulus = 12'(m); rd_hi = hi; rd_lo = lo;
    #2;
    chk("R7", rd_hi_data, exp_cnt >> 8);
    chk("R8", rd_lo_data, (m_held != 0) ? m_lat : (exp_cnt & 255));
    @(posedge clk);
    #1;
    if (hi) begin m_held = 1; m_lat = exp_cnt & 255; end
    else if (lo) m_held = 0;
    if (en) k++; else k = 0;
    me = (m < 2) ? 2 : m;
    exp_cnt = pos_count(k, ctr, me);
    exp_rel = pos_reload(k, ctr, me);
    chk(tag, cnt_o, exp_cnt);
    chk("R6", reload, exp_rel);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1", cnt_o, 0);
    chk("R1", reload, 0);
    chk("R1", rd_lo_data, 0);
    chk("R1", rd_hi_data, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", cnt_o, 0);

    // R3 / R5: edge-aligned sweep over small moduli
    for (int m = 0; m < 10; m++) begin
      int me = (m < 2) ? 2 : m;
      step(0, 0, m, 0, 0, "R2");
      for (int i = 0; i < 3 * me + 3; i++)
        step(1, 0, m, 0, 0, (m < 2) ? "R5" : "R3");
    end

    // R4 / R5: center-aligned sweep over small moduli
    for (int m = 0; m < 10; m++) begin
      int me = (m < 2) ? 2 : m;
      step(0, 1, m, 0, 0, "R2");
      for (int i = 0; i < 6 * (me - 1) + 3; i++)
        step(1, 1, m, 0, 0, (m < 2) ? "R5" : "R4");
    end

    // R2: disable mid-run holds zero
    for (int i = 0; i < 4; i++) step(0, 0, 7, 0, 0, "R2");

    // R7 / R8: large modulus, capture then release
    for (int i = 0; i < 270; i++) step(1, 0, 300, 0, 0, "R3");
    step(1, 0, 300, 1, 0, "R3");
    for (int i = 0; i < 6; i++) step(1, 0, 300, 0, 0, "R3");
    step(1, 0, 300, 0, 1, "R3");
    for (int i = 0; i < 3; i++) step(1, 0, 300, 0, 0, "R3");

    // R9: both strobes in one cycle; capture stays
    begin
      int saved;
      saved = exp_cnt & 255;
      step(1, 0, 300, 1, 1, "R3");
      chk("R9", rd_lo_data, saved);
      for (int i = 0; i < 4; i++) step(1, 0, 300, 0, 0, "R3");
      chk("R9", rd_lo_data, saved);
    end

    // R8: capture survives a disable, then release
    for (int i = 0; i < 3; i++) step(0, 0, 300, 0, 0, "R2");
    step(0, 0, 300, 0, 1, "R2");
    step(0, 0, 300, 0, 0, "R2");

    // R4: center mode with large modulus, through high byte both ways
    for (int i = 0; i < 700; i++)
      step(1, 1, 300, (i % 97) == 50, (i % 97) == 60, "R4");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule